// File: doc/BRIEF.md
# Dual-Overflow Watchdog Timer

This block is a watchdog timer with two clocks. Software reaches it over a small register bus that runs on the bus clock. The counter runs on a separate counting clock. Software sets a 12-bit period field, clears the counter and turns counting on. Each overflow cycle lasts (N+1)·2^SHIFT counting-clock cycles.

The first overflow without a refresh raises an interrupt flag. The counter then starts again from zero. A second overflow while that flag is still pending latches the reset output. Writing 1 to the interrupt register is the refresh: it clears both the counter and the flag. Software can also inject a parity error. When the parity-control bit is 0, that error latches the reset at once.

Every bus write is passed into the counting domain through a toggle handshake, one write at a time. The bus is valid/ready. A transfer completes on a clock edge where both `bus_valid` and `bus_ready` are high. `bus_ready` drops for the whole time a write is crossing, which holds off all further transfers. Reads never stall anything else. `bus_rdata` is combinational from `bus_addr`.

Top module: `wdt_dual_ovf`

## Requirements
- R1: The period register (word index 1) keeps bits [31:20] of the written data as the period field N. Bits [19:0] are discarded, and a read returns N in bits [31:20] with zeros below.
- R2: While counting is enabled, the counter advances once per counting clock. After (N+1)·2^SHIFT cycles it wraps to zero. The first such wrap sets the interrupt flag, which drives `irq` high.
- R3: A wrap that happens while the interrupt flag is already set drives `wdt_rst` high.
- R4: Writing data with bit 0 set to the interrupt register (word index 3) clears both the counter and the interrupt flag, and stops a reset that would otherwise be latched on that same edge. Writing 0 there changes nothing.
- R5: Bit 0 of the control register (word index 0) enables counting. When it is 0 the counter holds its value. Any write to the counter register (word index 2) sets the counter to zero.
- R6: Writing data with bit 0 set to the parity-force register (word index 5) drives `wdt_rst` high if the parity-control register (word index 4) holds 0. If that register holds 1, the write has no effect.
- R7: A write accepted at bus edge k takes effect on the third counting-clock edge after k (counted with equal clocks). `bus_ready` is low for the five bus cycles that follow edge k.
- R8: Once high, `wdt_rst` stays high through refreshes. Only `rst_cnt_n` clears it.
- R9: A write to the period register made while counting is enabled is ignored. Both the active period and the read-back value stay the same.
- R10: Reads return the enable bit (index 0), the parity-control bit (index 4) and the period field (index 1) as written. Index 2 returns a snapshot of the counter and index 3 returns a snapshot of the flag. Both snapshots are taken through a handshake and lag the live values by only a few cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register bus clock |
| rst_bus_n | input | 1 | Asynchronous active-low reset, bus domain |
| clk_cnt | input | 1 | Counting clock |
| rst_cnt_n | input | 1 | Asynchronous active-low reset, counting domain; the only way to clear `wdt_rst` |
| bus_valid | input | 1 | Transfer request |
| bus_ready | output | 1 | Low while a write is crossing into the counting domain |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt flag (counting domain) |
| wdt_rst | output | 1 | Latched reset request (counting domain) |

## Verification
The bench builds the block with SHIFT = 4, so one overflow cycle is 16·(N+1) clocks. Periods of 1 and 3 units let both overflows, refreshes, and the write lockout all occur within a few hundred cycles. The bench drives both clocks from one source. With equal clocks the three-edge apply latency and the five-cycle ready gap are exact, so the model can predict `irq`, `wdt_rst` and `bus_ready` on every cycle. Counter read-back is checked against a small lag window, since the snapshot handshake defines no exact latency.

// File: rtl/wdt_dual_pkg.sv
package wdt_dual_pkg;
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_PERIOD = 3'd1,
    REG_COUNT  = 3'd2,
    REG_INT    = 3'd3,
    REG_PCTL   = 3'd4,
    REG_PFORCE = 3'd5
  } reg_e;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/wdt_bus_side.sv
module wdt_bus_side
  import wdt_dual_pkg::*;
#(
  parameter int PERIOD_W = 12,
  parameter int SHIFT    = 20,
  localparam int CW      = PERIOD_W + SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  output logic          bus_ready,
  input  logic          bus_write,
  input  logic [2:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          req_tgl,
  output logic [2:0]    hold_addr,
  output logic [31:0]   hold_data,
  input  logic          ack_tgl,
  output logic          snap_req,
  input  logic          snap_ack,
  input  logic [CW-1:0] snap_cnt,
  input  logic          snap_flag
);
  logic                ack_s, snap_ack_s, pend, accept_wr;
  logic                sh_en, sh_pctl, rd_flag;
  logic [PERIOD_W-1:0] sh_per;
  logic [CW-1:0]       rd_cnt;

  wdt_sync #(.W(1)) u_ack_sync  (.clk(clk), .rst_n(rst_n), .d(ack_tgl),  .q(ack_s));
  wdt_sync #(.W(1)) u_snap_sync (.clk(clk), .rst_n(rst_n), .d(snap_ack), .q(snap_ack_s));

  assign pend      = req_tgl != ack_s;
  assign bus_ready = !pend;
  assign accept_wr = bus_valid && bus_ready && bus_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl   <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      sh_en     <= 1'b0;
      sh_pctl   <= 1'b0;
      sh_per    <= '0;
    end else if (accept_wr) begin
      req_tgl   <= ~req_tgl;
      hold_addr <= bus_addr;
      hold_data <= bus_wdata;
      case (reg_e'(bus_addr))
        REG_CTRL:   sh_en   <= bus_wdata[0];
        REG_PCTL:   sh_pctl <= bus_wdata[0];
        REG_PERIOD: if (!sh_en) sh_per <= bus_wdata[31:32-PERIOD_W];
        default: ;
      endcase
    end
  end

  // Continuous snapshot loop: request, wait for acknowledge, copy, repeat.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_req <= 1'b0;
      rd_cnt   <= '0;
      rd_flag  <= 1'b0;
    end else if (snap_ack_s == snap_req) begin
      rd_cnt   <= snap_cnt;
      rd_flag  <= snap_flag;
      snap_req <= ~snap_req;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (reg_e'(bus_addr))
      REG_CTRL:   bus_rdata = {31'd0, sh_en};
      REG_PERIOD: bus_rdata = {sh_per, {(32-PERIOD_W){1'b0}}};
      REG_COUNT:  bus_rdata = 32'(rd_cnt);
      REG_INT:    bus_rdata = {31'd0, rd_flag};
      REG_PCTL:   bus_rdata = {31'd0, sh_pctl};
      default:    bus_rdata = '0;
    endcase
  end

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> ($stable(hold_data) && $stable(hold_addr)));
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_wr |=> !bus_ready);
  p_shadow_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sh_en |=> $stable(sh_per));
endmodule

// File: rtl/wdt_cnt_side.sv
module wdt_cnt_side
  import wdt_dual_pkg::*;
#(
  parameter int PERIOD_W = 12,
  parameter int SHIFT    = 20,
  localparam int CW      = PERIOD_W + SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_tgl,
  input  logic [2:0]    hold_addr,
  input  logic [31:0]   hold_data,
  output logic          ack_tgl,
  input  logic          snap_req,
  output logic          snap_ack,
  output logic [CW-1:0] snap_cnt,
  output logic          snap_flag,
  output logic          irq,
  output logic          wdt_rst
);
  logic                req_s, req_d, apply, snap_s, snap_d, snap_take, ovf;
  logic                en_q, en_n, flag_q, flag_n, rst_q, rst_nx, pctl_q, pctl_n;
  logic [PERIOD_W-1:0] per_q, per_n;
  logic [CW-1:0]       cnt_q, cnt_n, last;

  wdt_sync #(.W(1)) u_req_sync  (.clk(clk), .rst_n(rst_n), .d(req_tgl),  .q(req_s));
  wdt_sync #(.W(1)) u_snap_sync (.clk(clk), .rst_n(rst_n), .d(snap_req), .q(snap_s));

  assign apply     = req_s != req_d;
  assign snap_take = snap_s != snap_d;
  assign last      = {per_q, {SHIFT{1'b1}}};
  assign ovf       = en_q && (cnt_q == last);

  always_comb begin
    cnt_n  = cnt_q;
    flag_n = flag_q;
    rst_nx = rst_q;
    en_n   = en_q;
    per_n  = per_q;
    pctl_n = pctl_q;
    if (en_q) cnt_n = ovf ? '0 : cnt_q + 1'b1;
    if (ovf) begin
      if (flag_q) rst_nx = 1'b1;
      else        flag_n = 1'b1;
    end
    if (apply) begin
      case (reg_e'(hold_addr))
        REG_CTRL:   en_n = hold_data[0];
        REG_PERIOD: if (!en_q) per_n = hold_data[31:32-PERIOD_W];
        REG_COUNT:  cnt_n = '0;
        REG_INT: if (hold_data[0]) begin
          cnt_n  = '0;
          flag_n = 1'b0;
          rst_nx = rst_q;
        end
        REG_PCTL:   pctl_n = hold_data[0];
        REG_PFORCE: if (hold_data[0] && !pctl_q) rst_nx = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d     <= 1'b0;
      ack_tgl   <= 1'b0;
      snap_d    <= 1'b0;
      snap_ack  <= 1'b0;
      snap_cnt  <= '0;
      snap_flag <= 1'b0;
      cnt_q     <= '0;
      flag_q    <= 1'b0;
      rst_q     <= 1'b0;
      en_q      <= 1'b0;
      per_q     <= '0;
      pctl_q    <= 1'b0;
    end else begin
      req_d  <= req_s;
      snap_d <= snap_s;
      if (apply) ack_tgl <= ~ack_tgl;
      if (snap_take) begin
        snap_cnt  <= cnt_q;
        snap_flag <= flag_q;
        snap_ack  <= ~snap_ack;
      end
      cnt_q  <= cnt_n;
      flag_q <= flag_n;
      rst_q  <= rst_nx;
      en_q   <= en_n;
      per_q  <= per_n;
      pctl_q <= pctl_n;
    end
  end

  assign irq     = flag_q;
  assign wdt_rst = rst_q;

  p_rst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);
  p_period_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(per_q));
  p_second_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_q) && !$past(apply)) |-> $past(flag_q));
  p_flag_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (cnt_q == '0));
endmodule

// File: rtl/wdt_dual_ovf.sv
module wdt_dual_ovf #(
  parameter int PERIOD_W = 12,
  parameter int SHIFT    = 20,
  localparam int CW      = PERIOD_W + SHIFT
) (
  input  logic        clk_bus,
  input  logic        rst_bus_n,
  input  logic        clk_cnt,
  input  logic        rst_cnt_n,
  input  logic        bus_valid,
  output logic        bus_ready,
  input  logic        bus_write,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        wdt_rst
);
  logic          req_tgl, ack_tgl, snap_req, snap_ack, snap_flag;
  logic [2:0]    hold_addr;
  logic [31:0]   hold_data;
  logic [CW-1:0] snap_cnt;

  wdt_bus_side #(.PERIOD_W(PERIOD_W), .SHIFT(SHIFT)) u_bus (
    .clk(clk_bus), .rst_n(rst_bus_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_tgl(req_tgl), .hold_addr(hold_addr), .hold_data(hold_data),
    .ack_tgl(ack_tgl), .snap_req(snap_req), .snap_ack(snap_ack),
    .snap_cnt(snap_cnt), .snap_flag(snap_flag)
  );

  wdt_cnt_side #(.PERIOD_W(PERIOD_W), .SHIFT(SHIFT)) u_cnt (
    .clk(clk_cnt), .rst_n(rst_cnt_n),
    .req_tgl(req_tgl), .hold_addr(hold_addr), .hold_data(hold_data),
    .ack_tgl(ack_tgl), .snap_req(snap_req), .snap_ack(snap_ack),
    .snap_cnt(snap_cnt), .snap_flag(snap_flag),
    .irq(irq), .wdt_rst(wdt_rst)
  );
endmodule

// File: tb/wdt_dual_ovf_tb.sv
module wdt_dual_ovf_tb;
  localparam int CLK_NS = 10;
  localparam int PW     = 12;
  localparam int SH     = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_ready;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq, wdt_rst;

  always #(CLK_NS/2) clk = ~clk;

  wdt_dual_ovf #(.PERIOD_W(PW), .SHIFT(SH)) u_dut (
    .clk_bus(clk), .rst_bus_n(rst_n), .clk_cnt(clk), .rst_cnt_n(rst_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wdt_rst(wdt_rst)
  );

  int checks = 0, errors = 0;
  // behavioural reference state
  int m_en, m_per, m_cnt, m_flag, m_rst, m_pctl, m_rc, p_cd, m_seen;
  int p_addr, p_data, acc_addr, acc_data;
  bit acc_flag = 1'b0;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_per = 0; m_cnt = 0; m_flag = 0; m_rst = 0; m_pctl = 0;
      m_rc = 0; p_cd = 0; acc_flag = 1'b0;
    end else begin
      int lim, n_cnt, n_flag, n_rst, n_en, n_per, n_pctl;
      bit ovf;
      lim = (m_per + 1) << SH;
      ovf = (m_en != 0) && (m_cnt == lim - 1);
      n_cnt = m_en != 0 ? (ovf ? 0 : m_cnt + 1) : m_cnt;
      n_flag = m_flag; n_rst = m_rst; n_en = m_en; n_per = m_per; n_pctl = m_pctl;
      if (ovf) begin
        if (m_flag != 0) n_rst = 1; else n_flag = 1;
      end
      if (p_cd > 0) begin
        p_cd--;
        if (p_cd == 0) begin
          case (p_addr)
            0: n_en = p_data & 1;
            1: if (m_en == 0) n_per = (p_data >> 20) & 12'hFFF;
            2: n_cnt = 0;
            3: if ((p_data & 1) != 0) begin n_cnt = 0; n_flag = 0; n_rst = m_rst; end
            4: n_pctl = p_data & 1;
            5: if ((p_data & 1) != 0 && m_pctl == 0) n_rst = 1;
            default: ;
          endcase
        end
      end
      m_cnt = n_cnt; m_flag = n_flag; m_rst = n_rst;
      m_en = n_en; m_per = n_per; m_pctl = n_pctl;
      if (acc_flag) begin
        acc_flag = 1'b0; p_cd = 3; p_addr = acc_addr; p_data = acc_data; m_rc = 5;
      end else if (m_rc > 0) m_rc--;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", irq, m_flag, "irq per cycle");
      chk("R3", wdt_rst, m_rst, "wdt_rst per cycle");
      chk("R7", bus_ready, m_rc == 0, "bus_ready per cycle");
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    while (!bus_ready) @(negedge clk);
    acc_addr = a; acc_data = d; acc_flag = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'(a);
    while (!bus_ready) @(negedge clk);
    #1 v = bus_rdata; m_seen = m_cnt;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, v2;
    do_reset();
    idle(2);
    chk("R8", wdt_rst, 0, "reset state wdt_rst");
    chk("R2", irq, 0, "reset state irq");
    rd(0, v); chk("R10", v, 0, "reset ctrl readback");
    rd(1, v); chk("R1", v, 0, "reset period readback");

    // R1: period N=2, junk in low bits
    wr(1, 32'h002F_FFFF);
    rd(1, v); chk("R1", v, 32'h0020_0000, "period field readback");
    wr(2, 0);
    wr(0, 1);
    chk("R7", bus_ready, 0, "ready low right after write");
    rd(0, v); chk("R10", v, 1, "enable readback");
    idle(20);
    rd(2, v);
    checks++;
    if (!(v <= m_seen && v + 12 >= m_seen)) begin
      errors++;
      $display("FAIL R10 counter snapshot: actual %0d expected near %0d", v, m_seen);
    end
    idle(40);
    chk("R2", irq, 1, "first overflow sets irq");
    chk("R3", wdt_rst, 0, "no reset after one overflow");
    rd(3, v); chk("R10", v, 1, "flag readback");
    // R9: period write ignored while enabled
    wr(1, 32'h00F0_0000);
    rd(1, v); chk("R9", v, 32'h0020_0000, "period locked while enabled");
    wr(3, 0); idle(4);
    chk("R4", irq, 1, "writing 0 to int register no effect");
    wr(3, 1); idle(4);
    chk("R4", irq, 0, "refresh clears irq");
    idle(100);
    chk("R3", wdt_rst, 1, "second overflow asserts reset");
    wr(3, 1); idle(6);
    chk("R8", wdt_rst, 1, "refresh leaves reset asserted");
    do_reset(); idle(2);
    chk("R8", wdt_rst, 0, "block reset clears wdt_rst");

    // R6: parity force
    wr(4, 1); wr(5, 1); idle(5);
    chk("R6", wdt_rst, 0, "parity force suppressed when control=1");
    wr(4, 0); wr(5, 1); idle(5);
    chk("R6", wdt_rst, 1, "parity force asserts reset");
    do_reset(); idle(2);

    // R5: enable/hold and counter clear, N=0
    wr(0, 1); idle(4);
    wr(0, 0); idle(12);
    rd(2, v); rd(2, v2);
    chk("R5", v2, v, "counter holds while disabled");
    chk("R5", (v != 0), 1, "counter advanced while enabled");
    wr(2, 0); idle(12);
    rd(2, v); chk("R5", v, 0, "counter write clears");
    wr(0, 1);
    for (int i = 0; i < 10; i++) wr(3, 1);
    chk("R4", irq, 0, "regular refresh prevents overflow");
    chk("R3", wdt_rst, 0, "no reset under regular refresh");
    idle(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule